// File: doc/BRIEF.md
# Endpoint Handshake and Halt Controller

This block sits beside one endpoint of a full-speed device controller and decides which handshake goes back to the host at the end of each received token or data packet: ACK, NAK or STALL. It keeps the endpoint's halt request, which firmware arms and disarms with one-cycle strobes. It also keeps three interrupt flags (SETUP received, OUT data received, STALL sent), which it combines under a mask into one endpoint interrupt line. The buffer logic supplies a retry indication. The buffer logic also receives a drop pulse when the data of the current packet must be discarded.

Two state machines carry the behaviour. The halt machine has the states `STALL_CLEAR` and `STALL_ARMED`. It moves from `STALL_CLEAR` to `STALL_ARMED` on a firmware set strobe, provided no clear arrives in the same cycle. It moves from `STALL_ARMED` to `STALL_CLEAR` on a firmware clear strobe or on a SETUP received by a control endpoint. The response machine has the states `RESP_IDLE`, `RESP_ACK_SETUP`, `RESP_ACK_DATA`, `RESP_NAK` and `RESP_STALL`. On a packet-end strobe it leaves `RESP_IDLE` for one of the four answer states. From any answer state it returns to `RESP_IDLE` after one cycle, or it goes straight to the next answer state when another packet ends in that cycle. The answer state drives the handshake code.

On control endpoints a SETUP is always accepted and cancels a pending halt. On other endpoints a SETUP is handled like any other request. The buffer-ownership read-backs (release and read-write-allowed) come from the buffer logic and read as zero while the endpoint is a control endpoint.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: After reset, `hs_code` is 2'b00, `pkt_drop`, `stall_req`, all three flags and `ep_irq` are 0.
- R2: A `fw_stall_set` strobe makes `stall_req` 1 from the next cycle. A `fw_stall_clr` strobe makes it 0 from the next cycle. When both strobes arrive in the same cycle, the clear wins.
- R3: While `stall_req` is 1 and `retry_req` is 0, an OUT (`pkt_kind` 2'b01) or an IN (`pkt_kind` 2'b10) is answered with STALL (`hs_code` 2'b11), and `pkt_drop` is 1. An OUT answered this way does not set `flag_rxout`.
- R4: Every STALL answer sets `flag_stalled` (flag bit 2) in the same cycle as the handshake.
- R5: On a control endpoint, a SETUP (`pkt_kind` 2'b00) is answered with ACK (2'b01), whatever `retry_req` and `stall_req` are. It sets `flag_rxstp` (bit 0), clears `stall_req` and `flag_stalled`, and never sets `flag_rxout`. This hardware clear wins over a firmware set strobe in the same cycle.
- R6: When `retry_req` is 1 at packet end, every packet other than a control SETUP is answered with NAK (2'b10) and `pkt_drop` is 1. No flag is set. This holds even while `stall_req` is 1.
- R7: On a non-control endpoint, a SETUP is answered like any other request: NAK if a retry is required, otherwise STALL if a halt is requested, otherwise ACK. It never changes `stall_req`.
- R8: With no retry and no halt, an OUT is answered with ACK and sets `flag_rxout` (bit 1). An IN is answered with ACK and sets no flag.
- R9: `hs_code` is non-zero only in the single cycle that follows a packet-end strobe. A packet of the reserved kind 2'b11 gets `hs_code` 2'b00. Packets that end on consecutive cycles each get their own answer.
- R10: A bit of `fw_flag_clr` (bit 0 SETUP, bit 1 OUT, bit 2 stalled) clears that flag on the next cycle. A hardware set of the same flag in the same cycle wins over the clear.
- R11: `ep_irq` is 1 exactly when some flag is 1 and its bit in `irq_mask` is 1. The mask uses the same bit order as the flags.
- R12: `fifocon_rd` and `rwall_rd` read 0 while `ep_is_ctrl` is 1. Otherwise they follow `fifocon_raw` and `rwall_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_is_ctrl | input | 1 | 1 when the endpoint is a control endpoint |
| pkt_end | input | 1 | One-cycle strobe at the end of a received token or packet |
| pkt_kind | input | 2 | 00 SETUP, 01 OUT, 10 IN, 11 reserved |
| retry_req | input | 1 | Buffer logic cannot take or supply data now |
| fw_stall_set | input | 1 | Firmware strobe that arms the halt request |
| fw_stall_clr | input | 1 | Firmware strobe that disarms the halt request |
| fw_flag_clr | input | 3 | Firmware clear strobes for the flags |
| irq_mask | input | 3 | Interrupt enables, one per flag |
| fifocon_raw | input | 1 | Buffer release bit from the buffer logic |
| rwall_raw | input | 1 | Read/write-allowed bit from the buffer logic |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |
| pkt_drop | output | 1 | Data of the answered packet must be discarded |
| stall_req | output | 1 | Halt request state |
| flag_rxstp | output | 1 | SETUP received flag |
| flag_rxout | output | 1 | OUT data received flag |
| flag_stalled | output | 1 | STALL sent flag |
| ep_irq | output | 1 | Aggregated endpoint interrupt |
| fifocon_rd | output | 1 | Buffer release bit as read back |
| rwall_rd | output | 1 | Read/write-allowed bit as read back |

## Verification
The bench builds the block with its default of three flags, which covers every flag, every mask bit and every pairing of a hardware event with a firmware clear. The endpoint type is an input, so one build reaches both the control path and the non-control path. The bench therefore covers a SETUP cancelling a halt and a SETUP that leaves it in place. It also covers retry overriding a halt, and packets ending on consecutive cycles.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;

    localparam int HS_W         = 2;
    localparam int KIND_W       = 2;
    localparam int NFLAG        = 3;
    localparam int FLAG_SETUP   = 0;
    localparam int FLAG_OUT     = 1;
    localparam int FLAG_STALLED = 2;

    typedef enum logic [HS_W-1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_SETUP = 2'b00,
        KIND_OUT   = 2'b01,
        KIND_IN    = 2'b10,
        KIND_RSVD  = 2'b11
    } pkt_kind_e;

endpackage

// File: rtl/ep_stall_fsm.sv
module ep_stall_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic fw_set,
    input  logic fw_clr,
    input  logic hw_clr,
    output logic halted
);

    typedef enum logic {
        STALL_CLEAR = 1'b0,
        STALL_ARMED = 1'b1
    } stall_state_e;

    stall_state_e state_q, state_d;

    // Next state: any clear source beats a set in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STALL_CLEAR: begin
                if (fw_set && !fw_clr && !hw_clr) begin
                    state_d = STALL_ARMED;
                end
            end
            STALL_ARMED: begin
                if (fw_clr || hw_clr) begin
                    state_d = STALL_CLEAR;
                end
            end
            default: state_d = STALL_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STALL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            STALL_ARMED: halted = 1'b1;
            default:     halted = 1'b0;
        endcase
    end

    // R2: clear strobe wins over set
    assert_clr_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fw_clr |=> !halted);

endmodule

// File: rtl/ep_resp_fsm.sv
module ep_resp_fsm
    import ep_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_end,
    input  logic [KIND_W-1:0] pkt_kind,
    input  logic              is_ctrl,
    input  logic              retry_req,
    input  logic              halted,
    output logic [HS_W-1:0]   hs_code,
    output logic              pkt_drop,
    output logic              ev_ctrl_setup,
    output logic              ev_out_taken,
    output logic              ev_stall_sent
);

    typedef enum logic [2:0] {
        RESP_IDLE      = 3'd0,
        RESP_ACK_SETUP = 3'd1,
        RESP_ACK_DATA  = 3'd2,
        RESP_NAK       = 3'd3,
        RESP_STALL     = 3'd4
    } resp_state_e;

    resp_state_e state_q, state_d;
    pkt_kind_e   kind;

    assign kind = pkt_kind_e'(pkt_kind);

    // Decision order: control SETUP, reserved kind, retry, halt, accept
    always_comb begin
        state_d       = RESP_IDLE;
        ev_ctrl_setup = 1'b0;
        ev_out_taken  = 1'b0;
        ev_stall_sent = 1'b0;
        if (pkt_end) begin
            if (is_ctrl && kind == KIND_SETUP) begin
                state_d       = RESP_ACK_SETUP;
                ev_ctrl_setup = 1'b1;
            end else if (kind == KIND_RSVD) begin
                state_d = RESP_IDLE;
            end else if (retry_req) begin
                state_d = RESP_NAK;
            end else if (halted) begin
                state_d       = RESP_STALL;
                ev_stall_sent = 1'b1;
            end else begin
                state_d      = RESP_ACK_DATA;
                ev_out_taken = (kind == KIND_OUT);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RESP_ACK_SETUP: begin hs_code = HS_ACK;   pkt_drop = 1'b0; end
            RESP_ACK_DATA:  begin hs_code = HS_ACK;   pkt_drop = 1'b0; end
            RESP_NAK:       begin hs_code = HS_NAK;   pkt_drop = 1'b1; end
            RESP_STALL:     begin hs_code = HS_STALL; pkt_drop = 1'b1; end
            default:        begin hs_code = HS_NONE;  pkt_drop = 1'b0; end
        endcase
    end

    // R9: an answer appears only after a packet-end strobe
    assert_idle_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_end |=> hs_code == HS_NONE);

endmodule

// File: rtl/ep_flag_bank.sv
module ep_flag_bank #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] hw_set,
    input  logic [NFLAG-1:0] hw_clr,
    input  logic [NFLAG-1:0] fw_clr,
    input  logic [NFLAG-1:0] mask,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);

    logic [NFLAG-1:0] flag_d;
    logic [NFLAG-1:0] flag_q;

    // Per flag: a hardware set wins over any clear in the same cycle
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign flag_d[i] = hw_set[i] ? 1'b1 :
                           ((hw_clr[i] || fw_clr[i]) ? 1'b0 : flag_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flags = flag_q;
    assign irq   = |(flag_q & mask);

    // R10: a hardware set is never lost to a firmware clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set & fw_clr) != '0 |=> (flags & $past(hw_set & fw_clr)) == $past(hw_set & fw_clr));

endmodule

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl
    import ep_hs_pkg::*;
#(
    parameter int FLAGS = NFLAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ep_is_ctrl,
    input  logic              pkt_end,
    input  logic [KIND_W-1:0] pkt_kind,
    input  logic              retry_req,
    input  logic              fw_stall_set,
    input  logic              fw_stall_clr,
    input  logic [FLAGS-1:0]  fw_flag_clr,
    input  logic [FLAGS-1:0]  irq_mask,
    input  logic              fifocon_raw,
    input  logic              rwall_raw,
    output logic [HS_W-1:0]   hs_code,
    output logic              pkt_drop,
    output logic              stall_req,
    output logic              flag_rxstp,
    output logic              flag_rxout,
    output logic              flag_stalled,
    output logic              ep_irq,
    output logic              fifocon_rd,
    output logic              rwall_rd
);

    logic             ev_ctrl_setup;
    logic             ev_out_taken;
    logic             ev_stall_sent;
    logic [FLAGS-1:0] hw_set;
    logic [FLAGS-1:0] hw_clr;
    logic [FLAGS-1:0] flags;

    ep_stall_fsm u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .fw_set (fw_stall_set),
        .fw_clr (fw_stall_clr),
        .hw_clr (ev_ctrl_setup),
        .halted (stall_req)
    );

    ep_resp_fsm u_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .pkt_end       (pkt_end),
        .pkt_kind      (pkt_kind),
        .is_ctrl       (ep_is_ctrl),
        .retry_req     (retry_req),
        .halted        (stall_req),
        .hs_code       (hs_code),
        .pkt_drop      (pkt_drop),
        .ev_ctrl_setup (ev_ctrl_setup),
        .ev_out_taken  (ev_out_taken),
        .ev_stall_sent (ev_stall_sent)
    );

    always_comb begin
        hw_set               = '0;
        hw_clr               = '0;
        hw_set[FLAG_SETUP]   = ev_ctrl_setup;
        hw_set[FLAG_OUT]     = ev_out_taken;
        hw_set[FLAG_STALLED] = ev_stall_sent;
        hw_clr[FLAG_STALLED] = ev_ctrl_setup;
    end

    ep_flag_bank #(.NFLAG(FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .hw_clr (hw_clr),
        .fw_clr (fw_flag_clr),
        .mask   (irq_mask),
        .flags  (flags),
        .irq    (ep_irq)
    );

    assign flag_rxstp   = flags[FLAG_SETUP];
    assign flag_rxout   = flags[FLAG_OUT];
    assign flag_stalled = flags[FLAG_STALLED];

    // Buffer-ownership bits have no meaning on a control endpoint
    assign fifocon_rd = fifocon_raw & ~ep_is_ctrl;
    assign rwall_rd   = rwall_raw & ~ep_is_ctrl;

    // R5: control SETUP is accepted and cancels the halt
    assert_setup_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end && ep_is_ctrl && pkt_kind == KIND_SETUP |=>
        hs_code == HS_ACK && !stall_req && !flag_stalled && flag_rxstp);

    // R6: retry beats halt
    assert_retry_nak_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end && retry_req && pkt_kind != KIND_RSVD &&
        !(ep_is_ctrl && pkt_kind == KIND_SETUP) |=> hs_code == HS_NAK && pkt_drop);

    // R4: each STALL sent sets the stalled flag
    assert_stall_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end && stall_req && !retry_req && pkt_kind != KIND_RSVD &&
        !(ep_is_ctrl && pkt_kind == KIND_SETUP) |=> hs_code == HS_STALL && flag_stalled);

    // R3: a stalled OUT leaves the OUT flag alone
    assert_no_rxout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end && pkt_kind == KIND_OUT && stall_req && !retry_req && !fw_flag_clr[FLAG_OUT]
        |=> flag_rxout == $past(flag_rxout));

    // R7: a non-control SETUP keeps the halt
    assert_keep_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end && !ep_is_ctrl && pkt_kind == KIND_SETUP && stall_req && !fw_stall_clr
        |=> stall_req);

endmodule

// File: tb/sim_ep_handshake_ctrl.sv
module sim_ep_handshake_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ep_is_ctrl = 1'b0;
    logic       pkt_end = 1'b0;
    logic [1:0] pkt_kind = 2'b00;
    logic       retry_req = 1'b0;
    logic       fw_stall_set = 1'b0;
    logic       fw_stall_clr = 1'b0;
    logic [2:0] fw_flag_clr = 3'b000;
    logic [2:0] irq_mask = 3'b111;
    logic       fifocon_raw = 1'b0;
    logic       rwall_raw = 1'b0;
    logic [1:0] hs_code;
    logic       pkt_drop, stall_req, flag_rxstp, flag_rxout, flag_stalled;
    logic       ep_irq, fifocon_rd, rwall_rd;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ep_handshake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ep_is_ctrl(ep_is_ctrl), .pkt_end(pkt_end),
        .pkt_kind(pkt_kind), .retry_req(retry_req), .fw_stall_set(fw_stall_set),
        .fw_stall_clr(fw_stall_clr), .fw_flag_clr(fw_flag_clr), .irq_mask(irq_mask),
        .fifocon_raw(fifocon_raw), .rwall_raw(rwall_raw), .hs_code(hs_code),
        .pkt_drop(pkt_drop), .stall_req(stall_req), .flag_rxstp(flag_rxstp),
        .flag_rxout(flag_rxout), .flag_stalled(flag_stalled), .ep_irq(ep_irq),
        .fifocon_rd(fifocon_rd), .rwall_rd(rwall_rd)
    );

    typedef struct {
        logic [1:0] hs;
        logic       drop;
        logic       stall;
        logic [2:0] flags;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic       m_stall = 1'b0;
    logic [2:0] m_flags = 3'b000;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Firmware strobes only; called at a negedge, checks one cycle later
    task automatic fw(input logic fset, input logic fclr, input logic [2:0] fflag, input string req);
        fw_stall_set = fset;
        fw_stall_clr = fclr;
        fw_flag_clr  = fflag;
        m_flags = m_flags & ~fflag;
        if (fclr) m_stall = 1'b0;
        else if (fset) m_stall = 1'b1;
        @(negedge clk);
        fw_stall_set = 1'b0;
        fw_stall_clr = 1'b0;
        fw_flag_clr  = 3'b000;
        check(req, "stall_req", stall_req, m_stall);
        check(req, "flags", {flag_stalled, flag_rxout, flag_rxstp}, m_flags);
    endtask

    // Driver: one packet end, with optional same-cycle firmware strobes
    task automatic pkt(input logic [1:0] kind, input logic rt, input logic fset,
                       input logic fclr, input logic [2:0] fflag, input string tag);
        exp_t e;
        logic setup_c;
        pkt_end      = 1'b1;
        pkt_kind     = kind;
        retry_req    = rt;
        fw_stall_set = fset;
        fw_stall_clr = fclr;
        fw_flag_clr  = fflag;
        setup_c      = ep_is_ctrl && kind == 2'b00;
        e.tag        = tag;
        m_flags      = m_flags & ~fflag;
        if (setup_c) begin
            e.hs = 2'b01;
            m_flags[2] = 1'b0;
            m_flags[0] = 1'b1;
        end else if (kind == 2'b11) begin
            e.hs = 2'b00;
        end else if (rt) begin
            e.hs = 2'b10;
        end else if (m_stall) begin
            e.hs = 2'b11;
            m_flags[2] = 1'b1;
        end else begin
            e.hs = 2'b01;
            if (kind == 2'b01) m_flags[1] = 1'b1;
        end
        if (setup_c || fclr) m_stall = 1'b0;
        else if (fset) m_stall = 1'b1;
        e.drop  = (e.hs == 2'b10) || (e.hs == 2'b11);
        e.stall = m_stall;
        e.flags = m_flags;
        e.irq   = |(m_flags & irq_mask);
        sb.push_back(e);
        @(negedge clk);
        pkt_end      = 1'b0;
        retry_req    = 1'b0;
        fw_stall_set = 1'b0;
        fw_stall_clr = 1'b0;
        fw_flag_clr  = 3'b000;
    endtask

    // Monitor: compares the answer in the cycle after each packet end
    logic mon_was;
    always @(posedge clk) begin
        exp_t e;
        mon_was = pkt_end;
        #2;
        if (rst_n) begin
            if (mon_was) begin
                if (sb.size() == 0) begin
                    check("R9", "scoreboard empty", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(e.tag, "hs_code", hs_code, e.hs);
                    check(e.tag, "pkt_drop", pkt_drop, e.drop);
                    check(e.tag, "stall_req", stall_req, e.stall);
                    check(e.tag, "flags", {flag_stalled, flag_rxout, flag_rxstp}, e.flags);
                    check("R11", "ep_irq", ep_irq, e.irq);
                end
            end else begin
                check("R9", "hs_code idle", hs_code, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "hs_code", hs_code, 0);
        check("R1", "stall_req", stall_req, 0);
        check("R1", "flags", {flag_stalled, flag_rxout, flag_rxstp}, 0);
        check("R1", "ep_irq", ep_irq, 0);
        check("R1", "pkt_drop", pkt_drop, 0);

        // Non-control endpoint
        pkt(2'b01, 0, 0, 0, 3'b000, "R8");        // OUT accepted
        pkt(2'b10, 0, 0, 0, 3'b000, "R8");        // IN accepted
        @(negedge clk);
        fw(0, 0, 3'b010, "R10");                  // clear OUT flag
        fw(1, 0, 3'b000, "R2");                   // arm halt
        pkt(2'b01, 0, 0, 0, 3'b000, "R3");        // OUT stalled
        pkt(2'b10, 0, 0, 0, 3'b000, "R3");        // IN stalled
        pkt(2'b10, 1, 0, 0, 3'b000, "R6");        // retry beats halt
        pkt(2'b00, 0, 0, 0, 3'b000, "R7");        // non-control SETUP stalled
        pkt(2'b00, 1, 0, 0, 3'b000, "R7");        // non-control SETUP NAKed
        @(negedge clk);
        fw(0, 1, 3'b100, "R2");                   // disarm, clear stalled flag
        fw(1, 1, 3'b000, "R2");                   // clear wins
        pkt(2'b00, 0, 0, 0, 3'b000, "R7");        // non-control SETUP accepted
        @(negedge clk);

        // Control endpoint
        ep_is_ctrl = 1'b1;
        fw(1, 0, 3'b000, "R2");
        pkt(2'b01, 0, 0, 0, 3'b000, "R4");        // OUT stalled on control
        pkt(2'b00, 1, 0, 0, 3'b000, "R5");        // SETUP accepted despite retry, halt cancelled
        @(negedge clk);
        fw(1, 0, 3'b000, "R2");
        pkt(2'b00, 0, 1, 0, 3'b000, "R5");        // hardware clear beats same-cycle set
        // Back-to-back answers
        pkt(2'b01, 0, 0, 0, 3'b000, "R8");
        pkt(2'b10, 1, 0, 0, 3'b000, "R6");
        pkt(2'b11, 0, 0, 0, 3'b000, "R9");        // reserved kind: no answer
        pkt(2'b01, 0, 0, 0, 3'b010, "R10");       // set beats same-cycle clear
        @(negedge clk);

        // R11 mask
        fw(0, 0, 3'b111, "R10");
        check("R11", "ep_irq all clear", ep_irq, 0);
        irq_mask = 3'b101;
        pkt(2'b01, 0, 0, 0, 3'b000, "R11");       // OUT flag set but masked
        @(negedge clk);
        check("R11", "ep_irq masked", ep_irq, 0);
        irq_mask = 3'b010;
        #1;
        check("R11", "ep_irq enabled", ep_irq, 1);

        // R12 buffer-ownership read-back
        fifocon_raw = 1'b1;
        rwall_raw   = 1'b1;
        #1;
        check("R12", "fifocon_rd control", fifocon_rd, 0);
        check("R12", "rwall_rd control", rwall_rd, 0);
        ep_is_ctrl = 1'b0;
        #1;
        check("R12", "fifocon_rd data", fifocon_rd, 1);
        check("R12", "rwall_rd data", rwall_rd, 1);

        repeat (3) @(negedge clk);
        check("R9", "scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule